// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns single bus-cycle requests from an internal port into the strobe waveforms of an asynchronous NAND flash bus. One request is one command, address, data-out or data-in cycle. The block asserts the chip enable and the matching latch enable (CLE for commands, ALE for addresses), waits a setup interval, drives the write or read strobe low for a programmed number of clocks and then high for another programmed number of clocks. After that it reports completion. Read data is captured from the bus a programmed number of clocks after the read strobe falls.

Every timing relation comes from a count input given in clocks: strobe low and high widths, capture point, the gaps write-to-read, read-to-write, read-to-read and address-to-data, and chip-enable setup. A count of zero is treated as one clock. The setup interval before a strobe is the largest of the chip-enable setup and every gap that applies given the previous completed cycle. The bus runs 8 bits wide or 16 bits wide. In 16-bit mode a host word carries its two bytes in bits 7:0 and 23:16.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset nand_ce_n, nand_we_n and nand_re_n are 1, nand_cle, nand_ale, nand_dq_oe and req_done are 0, req_ready is 1 and req_rdata is 0.
- R2: A request is taken only at a clock edge where req_ready is 1. req_ready is 1 exactly when no cycle is in progress, which includes the clock where req_done is 1. A request held while busy has no effect until the block is ready.
- R3: After a request is taken, nand_ce_n is 0 for W setup clocks, then the strobe is low for max(cfg_lo,1) clocks and high for max(cfg_hi,1) clocks. In the next clock nand_ce_n returns to 1 and req_done is 1 for exactly one clock.
- R4: req_kind encoding: 0 is a command (nand_cle = 1), 1 is an address (nand_ale = 1), 2 is data out and 3 is data in. The latch enable stays set for every clock in which nand_ce_n is 0. Kinds 0 to 2 pulse nand_we_n and kind 3 pulses nand_re_n.
- R5: On a data-in cycle, req_rdata loads the packed bus at the end of strobe clock A, where A = min(max(cfg_acc,1), max(cfg_lo,1)+max(cfg_hi,1)). Strobe clock 1 is the first clock with nand_re_n low. req_rdata changes at no other time.
- R6: W includes max(cfg_we2re,1) when a data-in follows a write-strobe cycle. It includes max(cfg_re2we,1) when a write-strobe cycle follows a data-in, and max(cfg_re2re,1) when a data-in follows a data-in.
- R7: W includes the address-to-data gap when a data cycle (kind 2 or 3) follows an address cycle. The gap uses cfg_adr2dat with its top bit forced to 0 when old_rev is 1, and is at least 1.
- R8: W is never less than max(cfg_cs,1). nand_ce_n is 0 at least one clock before any strobe falls.
- R9: nand_dq_oe is 1 during the strobe-low and strobe-high clocks of kinds 0 to 2 and 0 otherwise. It is never 1 while nand_re_n is 0.
- R10: In 8-bit mode (bus16 = 0), and for commands and addresses in either mode, nand_dq_out is {8'h00, req_wdata[7:0]}. An 8-bit read gives req_rdata = {24'h0, nand_dq_in[7:0]}.
- R11: In 16-bit mode, data-out drives nand_dq_out = {req_wdata[23:16], req_wdata[7:0]}. Data-in gives req_rdata = {8'h00, nand_dq_in[15:8], 8'h00, nand_dq_in[7:0]}.
- R12: The gaps of R6 and R7 depend only on the previous completed cycle. The first cycle after reset uses W = max(cfg_cs,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus16 | input | 1 | 1 selects the 16-bit bus |
| old_rev | input | 1 | 1 limits the address-to-data gap to 6 bits |
| cfg_lo | input | 8 | Strobe low width in clocks |
| cfg_hi | input | 8 | Strobe high width in clocks |
| cfg_acc | input | 8 | Read capture point in clocks after the read strobe falls |
| cfg_we2re | input | 8 | Write-strobe to read-strobe gap |
| cfg_re2we | input | 8 | Read-strobe to write-strobe gap |
| cfg_re2re | input | 8 | Read-strobe to read-strobe gap |
| cfg_adr2dat | input | 7 | Address-to-data gap |
| cfg_cs | input | 8 | Chip-enable setup clocks |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Cycle kind (see R4) |
| req_wdata | input | 32 | Host word for output cycles |
| req_ready | output | 1 | Block idle, request will be taken |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 32 | Packed read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus in |

## Verification
The assertions and the bench assume that bus16, old_rev and every count input are stable while a cycle is in progress, and that nand_dq_in is stable for the whole strobe phase of a read. The bench changes configuration only in clocks where the reference model shows the block idle. It drives nand_dq_in before each read request is issued. Requests are also held high through busy periods to confirm they are not taken early.

// File: rtl/nand_cyc_pkg.sv
package nand_cyc_pkg;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_WR   = 2'd2,
        KIND_RD   = 2'd3
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } cyc_phase_e;

endpackage

// File: rtl/nand_gap_calc.sv
module nand_gap_calc
    import nand_cyc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int ADR_W = 7
) (
    input  logic             last_valid,
    input  cyc_kind_e        last_kind,
    input  cyc_kind_e        new_kind,
    input  logic             old_rev,
    input  logic [CNT_W-1:0] cs_cnt,
    input  logic [CNT_W-1:0] we2re_cnt,
    input  logic [CNT_W-1:0] re2we_cnt,
    input  logic [CNT_W-1:0] re2re_cnt,
    input  logic [ADR_W-1:0] adr2dat_cnt,
    output logic [CNT_W-1:0] wait_cnt
);

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    function automatic logic [CNT_W-1:0] larger(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic [ADR_W-1:0] adr_masked;
    logic             prev_we;
    logic             prev_rd;
    logic             new_rd;
    logic             new_data;

    always_comb begin
        adr_masked = adr2dat_cnt;
        if (old_rev) begin
            adr_masked[ADR_W-1] = 1'b0;
        end
        prev_we  = last_valid && (last_kind != KIND_RD);
        prev_rd  = last_valid && (last_kind == KIND_RD);
        new_rd   = (new_kind == KIND_RD);
        new_data = (new_kind == KIND_RD) || (new_kind == KIND_WR);

        wait_cnt = at_least_one(cs_cnt);
        if (prev_we && new_rd) begin
            wait_cnt = larger(wait_cnt, at_least_one(we2re_cnt));
        end
        if (prev_rd && !new_rd) begin
            wait_cnt = larger(wait_cnt, at_least_one(re2we_cnt));
        end
        if (prev_rd && new_rd) begin
            wait_cnt = larger(wait_cnt, at_least_one(re2re_cnt));
        end
        if (last_valid && (last_kind == KIND_ADDR) && new_data) begin
            wait_cnt = larger(wait_cnt, at_least_one(CNT_W'(adr_masked)));
        end
    end

endmodule

// File: rtl/nand_data_pack.sv
module nand_data_pack
    import nand_cyc_pkg::*;
#(
    parameter int DQ_W   = 16,
    parameter int HOST_W = 32
) (
    input  logic              wide,
    input  cyc_kind_e         kind,
    input  logic [7:0]        lo_byte,
    input  logic [7:0]        hi_byte,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_word,
    output logic [HOST_W-1:0] host_word
);

    localparam int HALF = HOST_W / 2;

    always_comb begin
        dq_word = '0;
        dq_word[7:0] = lo_byte;
        if (wide && (kind == KIND_WR)) begin
            dq_word[15:8] = hi_byte;
        end
    end

    always_comb begin
        host_word = '0;
        host_word[7:0] = dq_in[7:0];
        if (wide) begin
            host_word[HALF+7:HALF] = dq_in[15:8];
        end
    end

endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
    import nand_cyc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADR_W  = 7,
    parameter int DQ_W   = 16,
    parameter int HOST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus16,
    input  logic              old_rev,
    input  logic [CNT_W-1:0]  cfg_lo,
    input  logic [CNT_W-1:0]  cfg_hi,
    input  logic [CNT_W-1:0]  cfg_acc,
    input  logic [CNT_W-1:0]  cfg_we2re,
    input  logic [CNT_W-1:0]  cfg_re2we,
    input  logic [CNT_W-1:0]  cfg_re2re,
    input  logic [ADR_W-1:0]  cfg_adr2dat,
    input  logic [CNT_W-1:0]  cfg_cs,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [HOST_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              req_done,
    output logic [HOST_W-1:0] req_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DQ_W-1:0]   nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DQ_W-1:0]   nand_dq_in
);

    localparam int SC_W = CNT_W + 1;
    localparam int HALF = HOST_W / 2;

    typedef struct packed {
        cyc_phase_e        phase;
        cyc_kind_e         kind;
        logic              wide;
        logic [DQ_W-1:0]   dq;
        logic [CNT_W-1:0]  cnt;
        logic [SC_W-1:0]   sc;
        logic              done;
        logic [HOST_W-1:0] rdata;
        logic              last_valid;
        cyc_kind_e         last_kind;
    } seq_state_t;

    seq_state_t s_d, s_q;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    cyc_kind_e         new_kind;
    logic [CNT_W-1:0]  wait_cnt;
    logic [DQ_W-1:0]   wr_word;
    logic [HOST_W-1:0] rd_word;
    logic [CNT_W-1:0]  lo_e, hi_e, acc_e;
    logic [SC_W-1:0]   strobe_len, cap_at;
    logic              unused_rsvd;

    assign new_kind    = cyc_kind_e'(req_kind);
    assign unused_rsvd = ^{req_wdata[HOST_W-1:HALF+8], req_wdata[HALF-1:8]};

    nand_gap_calc #(.CNT_W(CNT_W), .ADR_W(ADR_W)) i_gap (
        .last_valid (s_q.last_valid),
        .last_kind  (s_q.last_kind),
        .new_kind   (new_kind),
        .old_rev    (old_rev),
        .cs_cnt     (cfg_cs),
        .we2re_cnt  (cfg_we2re),
        .re2we_cnt  (cfg_re2we),
        .re2re_cnt  (cfg_re2re),
        .adr2dat_cnt(cfg_adr2dat),
        .wait_cnt   (wait_cnt)
    );

    nand_data_pack #(.DQ_W(DQ_W), .HOST_W(HOST_W)) i_pack (
        .wide     (s_q.phase == PH_IDLE ? bus16 : s_q.wide),
        .kind     (new_kind),
        .lo_byte  (req_wdata[7:0]),
        .hi_byte  (req_wdata[HALF+7:HALF]),
        .dq_in    (nand_dq_in),
        .dq_word  (wr_word),
        .host_word(rd_word)
    );

    always_comb begin
        lo_e       = at_least_one(cfg_lo);
        hi_e       = at_least_one(cfg_hi);
        acc_e      = at_least_one(cfg_acc);
        strobe_len = {1'b0, lo_e} + {1'b0, hi_e};
        cap_at     = ({1'b0, acc_e} < strobe_len) ? {1'b0, acc_e} : strobe_len;
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase = PH_SETUP;
                    s_d.kind  = new_kind;
                    s_d.wide  = bus16;
                    s_d.dq    = wr_word;
                    s_d.cnt   = wait_cnt - CNT_W'(1);
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_LOW;
                    s_d.cnt   = lo_e - CNT_W'(1);
                    s_d.sc    = '0;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_LOW, PH_HIGH: begin
                if ((s_q.kind == KIND_RD) && (s_q.sc == cap_at - SC_W'(1))) begin
                    s_d.rdata = rd_word;
                end
                s_d.sc = s_q.sc + SC_W'(1);
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end else if (s_q.phase == PH_LOW) begin
                    s_d.phase = PH_HIGH;
                    s_d.cnt   = hi_e - CNT_W'(1);
                end else begin
                    s_d.phase      = PH_IDLE;
                    s_d.done       = 1'b1;
                    s_d.last_valid = 1'b1;
                    s_d.last_kind  = s_q.kind;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, kind: KIND_CMD, wide: 1'b0, dq: '0, cnt: '0,
                     sc: '0, done: 1'b0, rdata: '0, last_valid: 1'b0,
                     last_kind: KIND_CMD};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        req_ready   = (s_q.phase == PH_IDLE);
        req_done    = s_q.done;
        req_rdata   = s_q.rdata;
        nand_ce_n   = (s_q.phase == PH_IDLE);
        nand_cle    = !nand_ce_n && (s_q.kind == KIND_CMD);
        nand_ale    = !nand_ce_n && (s_q.kind == KIND_ADDR);
        nand_we_n   = !((s_q.phase == PH_LOW) && (s_q.kind != KIND_RD));
        nand_re_n   = !((s_q.phase == PH_LOW) && (s_q.kind == KIND_RD));
        nand_dq_oe  = ((s_q.phase == PH_LOW) || (s_q.phase == PH_HIGH)) &&
                      (s_q.kind != KIND_RD);
        nand_dq_out = s_q.dq;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ce_n |-> (nand_we_n && nand_re_n && !nand_dq_oe && !nand_cle && !nand_ale));

    assert_done_after_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> $past(s_q.phase == PH_HIGH));

    assert_one_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    assert_rdata_only_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_rdata) |-> $past(s_q.kind == KIND_RD &&
                                      (s_q.phase == PH_LOW || s_q.phase == PH_HIGH)));

    assert_ce_before_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |-> $past(!nand_ce_n));

    assert_ce_before_re_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> $past(!nand_ce_n));

    assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nand_dq_oe |-> nand_re_n);

endmodule

// File: tb/test_nand_cycle_gen.sv
module test_nand_cycle_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus16 = 1'b0;
    logic        old_rev = 1'b0;
    logic [7:0]  cfg_lo = '0, cfg_hi = '0, cfg_acc = '0, cfg_we2re = '0;
    logic [7:0]  cfg_re2we = '0, cfg_re2re = '0, cfg_cs = '0;
    logic [6:0]  cfg_adr2dat = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, req_done;
    logic [31:0] req_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = '0;

    always #5 clk = ~clk;

    nand_cycle_gen i_nand_cycle_gen (
        .clk(clk), .rst_n(rst_n), .bus16(bus16), .old_rev(old_rev),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_acc(cfg_acc), .cfg_we2re(cfg_we2re),
        .cfg_re2we(cfg_re2we), .cfg_re2re(cfg_re2re), .cfg_adr2dat(cfg_adr2dat),
        .cfg_cs(cfg_cs), .req_valid(req_valid), .req_kind(req_kind),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_done(req_done),
        .req_rdata(req_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
    );

    typedef struct packed {
        logic        ce_n, cle, ale, we_n, re_n, oe, done, cap;
        logic [15:0] dq;
        logic [31:0] capv;
    } exp_t;

    exp_t        q[$];
    int          total = 0;
    int          bad = 0;
    string       tag = "R1";
    logic [31:0] exp_rdata = '0;
    int          last_kind = -1;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s]: actual %h expected %h", req, tag, act, exp);
        end
    endtask

    task automatic tick();
        exp_t cur;
        @(negedge clk);
        if (q.size() > 0) cur = q.pop_front();
        else cur = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0, we_n: 1'b1, re_n: 1'b1,
                     oe: 1'b0, done: 1'b0, cap: 1'b0, dq: '0, capv: '0};
        chk("R4 ce_n",  32'(nand_ce_n), 32'(cur.ce_n));
        chk("R4 cle",   32'(nand_cle),  32'(cur.cle));
        chk("R4 ale",   32'(nand_ale),  32'(cur.ale));
        chk("R3 we_n",  32'(nand_we_n), 32'(cur.we_n));
        chk("R3 re_n",  32'(nand_re_n), 32'(cur.re_n));
        chk("R9 dq_oe", 32'(nand_dq_oe), 32'(cur.oe));
        chk("R3 done",  32'(req_done),  32'(cur.done));
        chk("R2 ready", 32'(req_ready), 32'(cur.ce_n));
        chk("R5 rdata", req_rdata, exp_rdata);
        if (cur.oe) chk("R10 R11 dq_out", 32'(nand_dq_out), 32'(cur.dq));
        if (cur.cap) exp_rdata = cur.capv;
    endtask

    task automatic push_req(input int kind, input logic [31:0] wd, input logic [15:0] din);
        int   w, lo, hi, acc, adr;
        exp_t e;
        w = eff(int'(cfg_cs));
        if (last_kind >= 0 && last_kind != 3 && kind == 3) w = imax(w, eff(int'(cfg_we2re)));
        if (last_kind == 3 && kind != 3) w = imax(w, eff(int'(cfg_re2we)));
        if (last_kind == 3 && kind == 3) w = imax(w, eff(int'(cfg_re2re)));
        adr = old_rev ? (int'(cfg_adr2dat) % 64) : int'(cfg_adr2dat);
        if (last_kind == 1 && kind >= 2) w = imax(w, eff(adr));
        lo  = eff(int'(cfg_lo));
        hi  = eff(int'(cfg_hi));
        acc = eff(int'(cfg_acc));
        if (acc > lo + hi) acc = lo + hi;
        e = '0;
        e.ce_n = 1'b0; e.cle = (kind == 0); e.ale = (kind == 1);
        e.we_n = 1'b1; e.re_n = 1'b1;
        e.dq = (bus16 && kind == 2) ? {wd[23:16], wd[7:0]} : {8'h00, wd[7:0]};
        for (int i = 0; i < w; i++) q.push_back(e);
        for (int i = 0; i < lo + hi; i++) begin
            exp_t s = e;
            s.oe   = (kind != 3);
            s.we_n = !(i < lo && kind != 3);
            s.re_n = !(i < lo && kind == 3);
            s.cap  = (kind == 3 && i == acc - 1);
            s.capv = bus16 ? {8'h00, din[15:8], 8'h00, din[7:0]} : {24'h0, din[7:0]};
            q.push_back(s);
        end
        e = '0; e.ce_n = 1'b1; e.we_n = 1'b1; e.re_n = 1'b1; e.done = 1'b1;
        q.push_back(e);
        last_kind = kind;
    endtask

    task automatic wait_idle();
        while (q.size() > 0) tick();
    endtask

    task automatic issue(input int kind, input logic [31:0] wd, input logic [15:0] din);
        wait_idle();
        req_valid  = 1'b1;
        req_kind   = 2'(kind);
        req_wdata  = wd;
        nand_dq_in = din;
        push_req(kind, wd, din);
        tick();
        req_valid = 1'b0;
        req_wdata = 32'h5A5A_5A5A;
        wait_idle();
        tick();
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1 reset";
        chk("R1 ce_n", 32'(nand_ce_n), 32'd1);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 rdata", req_rdata, 32'd0);
        chk("R1 oe", 32'(nand_dq_oe), 32'd0);
        rst_n = 1'b1;
        tick();

        tag = "R12 R3 R4 R10 zero counts";
        issue(0, 32'h0000_0090, 16'h0);
        issue(1, 32'h0000_0012, 16'h0);
        issue(2, 32'hFFEE_DDA7, 16'h0);
        issue(3, 32'h0, 16'hBE5C);

        tag = "R3 R8 widths";
        cfg_lo = 8'd3; cfg_hi = 8'd2; cfg_cs = 8'd2;
        issue(0, 32'h0000_0070, 16'h0);
        cfg_cs = 8'd5;
        issue(1, 32'h0000_0044, 16'h0);

        tag = "R7 addr to write";
        cfg_cs = 8'd1; cfg_adr2dat = 7'd10;
        issue(1, 32'h0000_0001, 16'h0);
        issue(2, 32'h0000_0033, 16'h0);

        tag = "R7 R6 old_rev addr to read";
        old_rev = 1'b1; cfg_adr2dat = 7'h45; cfg_we2re = 8'd2; cfg_acc = 8'd2;
        issue(1, 32'h0000_0002, 16'h0);
        issue(3, 32'h0, 16'h00C3);
        old_rev = 1'b0;
        issue(1, 32'h0000_0003, 16'h0);
        issue(3, 32'h0, 16'h0071);

        tag = "R6 re2re and re2we";
        cfg_re2re = 8'd6; cfg_re2we = 8'd4;
        issue(3, 32'h0, 16'h0011);
        issue(0, 32'h0000_00FF, 16'h0);
        issue(2, 32'h0000_0022, 16'h0);
        issue(3, 32'h0, 16'h0033);

        tag = "R5 capture point";
        cfg_lo = 8'd4; cfg_hi = 8'd3;
        cfg_acc = 8'd2; issue(3, 32'h0, 16'h00A1);
        cfg_acc = 8'd7; issue(3, 32'h0, 16'h00B2);
        cfg_acc = 8'd9; issue(3, 32'h0, 16'h00C3);

        tag = "R11 16-bit";
        bus16 = 1'b1; cfg_lo = 8'd2; cfg_hi = 8'd1; cfg_acc = 8'd2;
        issue(2, 32'hAABB_CCDD, 16'h0);
        issue(3, 32'h0, 16'h1234);
        issue(0, 32'hAABB_CC80, 16'h0);
        bus16 = 1'b0;

        tag = "R2 held request";
        wait_idle();
        req_valid = 1'b1; req_kind = 2'd0; req_wdata = 32'h0000_0066;
        push_req(0, 32'h0000_0066, 16'h0);
        tick();
        while (q.size() > 0) tick();
        push_req(0, 32'h0000_0066, 16'h0);
        tick();
        req_valid = 1'b0;
        wait_idle();
        repeat (3) tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule